// File: doc/BRIEF.md
# Byte-Programming Controller for a Small Code Flash

This block sits between a programming host and a small on-chip code array, which is modelled here as plain registers. On each clock it samples an address, a data byte, a three-bit operation code and an active-low programming strobe. It runs timed byte writes, a timed write of either of two protection bits, and a whole-array blanking operation. It also serves verification reads of the code and a small fixed identification table.

A falling strobe edge starts a write, and the block then times the write itself. While it runs, the host can follow progress in either of two ways. The first is a ready output that stays low for the whole write. The second is to read back the address being written: until the new byte is stored, bit 7 of the read data is the inverse of bit 7 of the written byte. A write can only clear bits. To raise a bit back to one, the host must blank the entire array. When either protection bit is set, code reads return zero. No operation ever exposes the protection bits themselves.

All durations are counted in clocks. The write time and the blanking hold time are parameters, so a simulation can use short values while a real build uses values near 1.5 ms and 10 ms.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A write starts when the strobe `prog_n_i` is sampled high on one clock edge and low on the next while `mode_i` is 1 (code byte), 4 (protection bit A) or 5 (protection bit B) and the block is idle. The write then runs for exactly WRITE_CYC clocks, and its result becomes visible in the clock after the last one.
- R2: A completed code-byte write stores the old byte ANDed with the written byte, so no bit ever changes from 0 to 1 through a write.
- R3: `rdy_o` goes low in the clock that follows the strobe edge that starts a write. It stays low for WRITE_CYC clocks and then returns high.
- R4: A read (`mode_i` = 0) of the address being written, made while a code-byte write is in progress, returns {~data[7], 7'b0}. A read of any other address returns the stored byte. Once the write completes, the true stored byte appears.
- R5: If `mode_i` = 2 and the strobe is sampled low on ERASE_CYC consecutive edges, every byte becomes 8'hFF and both protection bits are cleared. This happens once per hold. A shorter hold changes nothing.
- R6: With `mode_i` = 3, address 12'h030 reads 8'h1E and address 12'h031 reads 8'h51. Address 12'h032 reads 8'hFF when HIGH_VPP = 1 and 8'h05 otherwise. Every other address reads 8'h00. The protection bits have no effect on these reads.
- R7: Writes of protection bits use the same timed cycle as code-byte writes. While either protection bit is set, every read with `mode_i` = 0 returns 8'h00.
- R8: While a write is running, strobe edges and changes of `mode_i` start nothing and do not hold or count an erase. The running write completes at the target and address it latched.
- R9: After reset, `rdy_o` is high, every byte reads 8'hFF and both protection bits are clear. Modes 1, 2, 4, 5, 6 and 7 return 8'h00 on `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Byte to write |
| mode_i | input | 3 | Operation code: 0 read, 1 write byte, 2 blank array, 3 identification read, 4 and 5 set protection bit A or B, 6 and 7 unused |
| prog_n_i | input | 1 | Active-low programming strobe |
| rdata_o | output | 8 | Read data, including the polling value |
| rdy_o | output | 1 | High when no write is running |

## Verification
The in-RTL properties check every cycle that ready falls right after a write is accepted and that the timer count stays in range. They also check that the timer's expiry ends busy, that the latched address and target do not move while busy, that a blank clears both protection bits, and that protected code reads and identification reads return only allowed values. Some behaviours only the bench scenarios can show, as the reference model compares each output on every clock. These are the AND-accumulation across repeated writes, the polling value for both polarities of bit 7, the short hold that must not blank the array, and strobes ignored in mid-write.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

    typedef enum logic [2:0] {
        FM_READ  = 3'd0,
        FM_BYTE  = 3'd1,
        FM_ERASE = 3'd2,
        FM_SIG   = 3'd3,
        FM_LOCKA = 3'd4,
        FM_LOCKB = 3'd5,
        FM_NOP6  = 3'd6,
        FM_NOP7  = 3'd7
    } fmode_e;

    typedef enum logic [1:0] {
        TGT_BYTE  = 2'd0,
        TGT_LOCKA = 2'd1,
        TGT_LOCKB = 2'd2
    } wtgt_e;

endpackage

// File: rtl/fp_cycle_timer.sv
module fp_cycle_timer #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o,
    output logic expire_o
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        expire_o = tmr_q.active && (tmr_q.cnt == '0);
        if (!tmr_q.active) begin
            if (start_i) begin
                tmr_d.active = 1'b1;
                tmr_d.cnt    = CW'(CYC - 1);
            end
        end else if (expire_o) begin
            tmr_d.active = 1'b0;
        end else begin
            tmr_d.cnt = tmr_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign active_o = tmr_q.active;

    // R1: the count never leaves its window
    a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.active |-> (tmr_q.cnt <= CW'(CYC - 1)));

    // R1: expiry always ends the busy interval
    a_r1_expire_ends: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !active_o);

endmodule

// File: rtl/fp_sig_rom.sv
module fp_sig_rom #(
    parameter int ADDR_W   = 12,
    parameter bit HIGH_VPP = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        byte_o
);
    logic [7:0] third_byte;

    generate
        if (HIGH_VPP) begin : g_hv
            assign third_byte = 8'hFF;
        end else begin : g_lv
            assign third_byte = 8'h05;
        end
    endgenerate

    always_comb begin
        unique case (addr_i)
            ADDR_W'(12'h030): byte_o = 8'h1E;
            ADDR_W'(12'h031): byte_o = 8'h51;
            ADDR_W'(12'h032): byte_o = third_byte;
            default:          byte_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flashprog_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WRITE_CYC = 300000,
    parameter int ERASE_CYC = 2000000,
    parameter bit HIGH_VPP  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic [2:0]        mode_i,
    input  logic              prog_n_i,
    output logic [7:0]        rdata_o,
    output logic              rdy_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int EW    = $clog2(ERASE_CYC + 1);

    typedef struct packed {
        logic              prog;
        logic [ADDR_W-1:0] last_a;
        logic [7:0]        last_d;
        wtgt_e             tgt;
        logic              lock_a;
        logic              lock_b;
        logic [EW-1:0]     ecnt;
        logic              edone;
    } st_t;

    st_t        st_d, st_q;
    logic [7:0] mem_q [DEPTH];
    fmode_e     mode;
    logic       busy, expire, start, erase_fire, held, fall, locked;
    logic [7:0] sig_byte;

    assign mode   = fmode_e'(mode_i);
    assign locked = st_q.lock_a | st_q.lock_b;

    fp_cycle_timer #(.CYC(WRITE_CYC)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .active_o (busy),
        .expire_o (expire)
    );

    fp_sig_rom #(.ADDR_W(ADDR_W), .HIGH_VPP(HIGH_VPP)) i_sig (
        .addr_i (addr_i),
        .byte_o (sig_byte)
    );

    // next-state computation
    always_comb begin
        st_d       = st_q;
        start      = 1'b0;
        erase_fire = 1'b0;
        fall       = st_q.prog && !prog_n_i;
        held       = (mode == FM_ERASE) && !prog_n_i;
        st_d.prog  = prog_n_i;

        if (!busy && fall &&
            (mode == FM_BYTE || mode == FM_LOCKA || mode == FM_LOCKB)) begin
            start       = 1'b1;
            st_d.last_a = addr_i;
            st_d.last_d = wdata_i;
            st_d.tgt    = (mode == FM_BYTE)  ? TGT_BYTE :
                          (mode == FM_LOCKA) ? TGT_LOCKA : TGT_LOCKB;
        end

        if (expire) begin
            if (st_q.tgt == TGT_LOCKA) st_d.lock_a = 1'b1;
            if (st_q.tgt == TGT_LOCKB) st_d.lock_b = 1'b1;
        end

        if (!held) begin
            st_d.ecnt  = '0;
            st_d.edone = 1'b0;
        end else if (!busy && !st_q.edone) begin
            if (st_q.ecnt == EW'(ERASE_CYC - 1)) begin
                erase_fire  = 1'b1;
                st_d.edone  = 1'b1;
                st_d.lock_a = 1'b0;
                st_d.lock_b = 1'b0;
            end else begin
                st_d.ecnt = st_q.ecnt + EW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.prog <= 1'b1;
            st_q.tgt  <= TGT_BYTE;
        end else begin
            st_q <= st_d;
        end
    end

    // behavioural array: blank on reset or erase, AND-merge on commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (erase_fire) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (expire && st_q.tgt == TGT_BYTE) begin
            mem_q[st_q.last_a] <= mem_q[st_q.last_a] & st_q.last_d;
        end
    end

    // read path
    always_comb begin
        rdata_o = 8'h00;
        if (mode == FM_SIG) begin
            rdata_o = sig_byte;
        end else if (mode == FM_READ && !locked) begin
            if (busy && st_q.tgt == TGT_BYTE && addr_i == st_q.last_a)
                rdata_o = {~st_q.last_d[7], 7'b0};
            else
                rdata_o = mem_q[addr_i];
        end
    end

    assign rdy_o = !busy;

    // R3: ready drops one clock after an accepted strobe edge
    a_r3_rdy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && st_q.prog && !prog_n_i && mode_i == 3'd1) |=> !rdy_o);

    // R8: latched address and target hold for the whole write
    a_r8_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !expire) |=> ($stable(st_q.last_a) && $stable(st_q.tgt)));

    // R5: a blank always leaves both protection bits clear
    a_r5_erase_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        erase_fire |=> (!st_q.lock_a && !st_q.lock_b));

    // R7: protected code reads are zero
    a_r7_locked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && mode_i == 3'd0) |-> (rdata_o == 8'h00));

    // R6: identification reads only return table values
    a_r6_sig_values: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd3) |-> (rdata_o inside {8'h00, 8'h1E, 8'h51, 8'hFF, 8'h05}));

endmodule

// File: tb/test_flash_prog_ctrl.sv
`timescale 1ns/100ps
module test_flash_prog_ctrl;
    localparam int W = 20;
    localparam int E = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [2:0]  mode = '0;
    logic        prog_n = 1'b1;
    logic [7:0]  rdata_o;
    logic        rdy_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    flash_prog_ctrl #(.ADDR_W(12), .WRITE_CYC(W), .ERASE_CYC(E), .HIGH_VPP(1'b1)) i_flash_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .mode_i(mode), .prog_n_i(prog_n), .rdata_o(rdata_o), .rdy_o(rdy_o)
    );

    // behavioural reference model
    logic [7:0]  mm [4096];
    int          left, ec, tg;
    bit          l1, l2, pv, ed, wb;
    logic [11:0] la;
    logic [7:0]  ld;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mm[i] = 8'hFF;
            left = 0; ec = 0; tg = 0; l1 = 0; l2 = 0; pv = 1; ed = 0; la = 0; ld = 0;
        end else begin
            wb = (left > 0);
            if (wb) begin
                left--;
                if (left == 0) begin
                    if (tg == 0) mm[la] = mm[la] & ld;
                    else if (tg == 1) l1 = 1;
                    else l2 = 1;
                end
            end else if (pv && !prog_n && (mode == 1 || mode == 4 || mode == 5)) begin
                left = W; la = addr; ld = wdata;
                tg = (mode == 1) ? 0 : (mode == 4) ? 1 : 2;
            end
            if (!(mode == 2 && !prog_n)) begin
                ec = 0; ed = 0;
            end else if (!wb && !ed) begin
                ec++;
                if (ec == E) begin
                    for (int i = 0; i < 4096; i++) mm[i] = 8'hFF;
                    l1 = 0; l2 = 0; ed = 1;
                end
            end
            pv = prog_n;
        end
    end

    function automatic logic [7:0] exp_rd();
        if (mode == 3) begin
            case (addr)
                12'h030: return 8'h1E;
                12'h031: return 8'h51;
                12'h032: return 8'hFF;
                default: return 8'h00;
            endcase
        end
        if (mode != 0 || l1 || l2) return 8'h00;
        if (left > 0 && tg == 0 && addr == la) return {~ld[7], 7'b0};
        return mm[addr];
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            total++;
            if (rdy_o !== (left == 0)) begin
                bad++;
                $display("FAIL R3 rdy_o actual=%0b expected=%0b t=%0t", rdy_o, (left == 0), $time);
            end
            total++;
            if (rdata_o !== exp_rd()) begin
                bad++;
                $display("FAIL %s rdata_o actual=%h expected=%h t=%0t",
                         (mode == 3) ? "R6" : (l1 || l2) ? "R7" : "R4", rdata_o, exp_rd(), $time);
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic rd(input logic [2:0] m, input logic [11:0] a);
        @(negedge clk);
        mode = m; addr = a;
        #1;
    endtask

    // start a write, optionally check polling value, then wait for completion
    task automatic wr(input logic [2:0] m, input logic [11:0] a, input logic [7:0] d,
                      input bit poll, input logic [7:0] poll_exp);
        @(negedge clk);
        mode = m; addr = a; wdata = d; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1; mode = 3'd0;
        #1;
        check("R3 ready low after strobe", {7'b0, rdy_o}, 8'h00);
        if (poll) check("R4 polling value", rdata_o, poll_exp);
        repeat (W - 1) @(negedge clk);
        #1;
        check("R1 still busy at last write clock", {7'b0, rdy_o}, 8'h00);
        @(negedge clk);
        #1;
        check("R1 ready after WRITE_CYC", {7'b0, rdy_o}, 8'h01);
    endtask

    task automatic erase_hold(input int n);
        @(negedge clk);
        mode = 3'd2; prog_n = 1'b0;
        repeat (n) @(negedge clk);
        prog_n = 1'b1; mode = 3'd0;
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        rd(3'd0, 12'h000);
        check("R9 blank after reset", rdata_o, 8'hFF);
        check("R9 ready after reset", {7'b0, rdy_o}, 8'h01);
        rd(3'd1, 12'h000);
        check("R9 non-read mode returns zero", rdata_o, 8'h00);

        // R1 R4 write with bit7 = 0, poll returns 0x80
        wr(3'd1, 12'h123, 8'h5A, 1'b1, 8'h80);
        check("R4 true data after write", rdata_o, 8'h5A);

        // R2 AND-merge
        wr(3'd1, 12'h123, 8'h0F, 1'b1, 8'h80);
        check("R2 bits only clear", rdata_o, 8'h0A);

        // R4 bit7 = 1 polls as 0x00, other address reads stored byte
        @(negedge clk);
        mode = 3'd1; addr = 12'h7FF; wdata = 8'hC3; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1; mode = 3'd0; #1;
        check("R4 polling inverted bit7", rdata_o, 8'h00);
        rd(3'd0, 12'h123);
        check("R4 other address during write", rdata_o, 8'h0A);
        repeat (W) @(negedge clk);
        rd(3'd0, 12'h7FF);
        check("R4 true data after second write", rdata_o, 8'hC3);

        // R8 strobes and mode changes during a write are ignored
        @(negedge clk);
        mode = 3'd1; addr = 12'h200; wdata = 8'h11; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1; mode = 3'd4;
        repeat (3) @(negedge clk);
        prog_n = 1'b0; addr = 12'h300;
        @(negedge clk);
        prog_n = 1'b1; mode = 3'd1;
        @(negedge clk);
        prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1; mode = 3'd0;
        repeat (W) @(negedge clk);
        rd(3'd0, 12'h200);
        check("R8 original write committed", rdata_o, 8'h11);
        check("R8 no extra write started", {7'b0, rdy_o}, 8'h01);
        rd(3'd0, 12'h300);
        check("R8 ignored address untouched", rdata_o, 8'hFF);

        // R6 identification table
        rd(3'd3, 12'h030); check("R6 first id byte", rdata_o, 8'h1E);
        rd(3'd3, 12'h031); check("R6 second id byte", rdata_o, 8'h51);
        rd(3'd3, 12'h032); check("R6 third id byte", rdata_o, 8'hFF);
        rd(3'd3, 12'h033); check("R6 other id address", rdata_o, 8'h00);

        // R5 short hold does nothing, full hold blanks
        erase_hold(E - 1);
        rd(3'd0, 12'h123);
        check("R5 short hold no effect", rdata_o, 8'h0A);
        erase_hold(E);
        rd(3'd0, 12'h123);
        check("R5 blank after full hold", rdata_o, 8'hFF);
        rd(3'd0, 12'h7FF);
        check("R5 second byte blank", rdata_o, 8'hFF);

        // R7 protection bit A
        wr(3'd1, 12'h010, 8'h33, 1'b0, 8'h00);
        wr(3'd4, 12'h000, 8'h00, 1'b0, 8'h00);
        rd(3'd0, 12'h010);
        check("R7 protected read zero (A)", rdata_o, 8'h00);
        rd(3'd3, 12'h030);
        check("R6 id read while protected", rdata_o, 8'h1E);
        erase_hold(E);
        rd(3'd0, 12'h010);
        check("R5 blank clears protection A", rdata_o, 8'hFF);

        // R7 protection bit B
        wr(3'd1, 12'h020, 8'h44, 1'b0, 8'h00);
        wr(3'd5, 12'h000, 8'h00, 1'b0, 8'h00);
        rd(3'd0, 12'h020);
        check("R7 protected read zero (B)", rdata_o, 8'h00);
        erase_hold(E);
        rd(3'd0, 12'h020);
        check("R5 blank clears protection B", rdata_o, 8'hFF);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule